// File: doc/BRIEF.md
# Indexed Element Broadcast Unit

This block takes one wide source vector together with a 7-bit immediate. From the immediate it works out an element width and an element index. It picks that element out of the source and repeats it across every lane of a result vector. The immediate is assembled from a 2-bit upper part and a 5-bit size code. The lowest set bit of the size code fixes the element width, which is 8, 16, 32, 64 or 128 bits. The immediate bits above that marker form the index, so a wider element leaves fewer index bits.

The vector width is a parameter: a multiple of 128 bits, from 128 to 2048. A request is qualified by a valid strobe. The result appears on registered outputs one clock later, together with its own valid. An index that points past the last element present at the configured width produces an all-zero result. An all-zero size code is reserved: it raises an illegal flag and also yields a zero result.

Top module: `bcast_unit`

## Requirements
- R1: The immediate is {req_hi, req_tsz}, with req_hi in bits 6..5. When req_tsz[0]=1 the elements are 8 bits wide and the index is immediate bits 6..1 (0..63).
- R2: When req_tsz[1:0]=2'b10 the elements are 16 bits wide and the index is immediate bits 6..2. When req_tsz[2:0]=3'b100 the elements are 32 bits wide and the index is immediate bits 6..3.
- R3: When req_tsz[3:0]=4'b1000 the elements are 64 bits wide and the index is immediate bits 6..4. When req_tsz=5'b10000 the elements are 128 bits wide and the index is immediate bits 6..5.
- R4: A request with req_tsz=5'b00000 gives res_illegal=1 and res_vec all zero in its result cycle.
- R5: When the index is greater than or equal to VLEN divided by the element width, res_vec is all zero and res_illegal is 0.
- R6: Otherwise every element lane of res_vec equals the selected source element. Element k occupies bits k*width and upward, with element 0 in the least significant bits.
- R7: res_valid is 1 in the cycle after each cycle in which req_valid is 1. res_vec and res_illegal carry that request's result in the same cycle.
- R8: In a cycle after req_valid is 0, res_valid and res_illegal are 0 and res_vec keeps its previous value.
- R9: While rst is high, res_valid, res_illegal and res_vec are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_vec | input | VLEN | Source vector, element 0 in the LSBs |
| req_hi | input | 2 | Upper two immediate bits |
| req_tsz | input | 5 | Size code, the lower five immediate bits |
| res_valid | output | 1 | Result strobe |
| res_vec | output | VLEN | Broadcast result |
| res_illegal | output | 1 | Reserved size code seen |

## Verification
The checker watches several rules on every clock. It checks that the result strobe trails the request by exactly one cycle, and that the illegal flag appears only with a strobe and only with a zero vector. It checks that a reserved size code always raises the flag and that an idle cycle leaves the result unchanged. It also checks that each legal result repeats itself with the period of the decoded element width. That period check cannot tell whether the right element was chosen, or whether an out-of-range index zeroed the result. Those two points are shown only by the bench's scenarios. The bench sweeps every size code with every upper-bit pair, every index at every width, and the indices at and past the element count of a 384-bit vector, and compares each result against its own model.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

    localparam int NUM_SIZES = 5;
    localparam int IDX_W     = 6;
    localparam int CODE_W    = 5;

    typedef enum logic [2:0] {
        ESZ_B = 3'd0,
        ESZ_H = 3'd1,
        ESZ_S = 3'd2,
        ESZ_D = 3'd3,
        ESZ_Q = 3'd4
    } esz_e;

    typedef struct packed {
        logic             illegal;
        esz_e             esz;
        logic [IDX_W-1:0] idx;
    } dec_t;

    // Width in bits of size class s (0 = byte).
    function automatic int esz_bits(input int s);
        return 8 << s;
    endfunction

    // Split the 7-bit immediate into element size and index.
    function automatic dec_t decode_imm(input logic [1:0] hi, input logic [CODE_W-1:0] tsz);
        logic [6:0] imm;
        dec_t       d;
        imm       = {hi, tsz};
        d.illegal = 1'b0;
        d.esz     = ESZ_B;
        d.idx     = '0;
        casez (tsz)
            5'b????1: begin d.esz = ESZ_B; d.idx = imm[6:1];          end
            5'b???10: begin d.esz = ESZ_H; d.idx = {1'b0, imm[6:2]};  end
            5'b??100: begin d.esz = ESZ_S; d.idx = {2'b0, imm[6:3]};  end
            5'b?1000: begin d.esz = ESZ_D; d.idx = {3'b0, imm[6:4]};  end
            5'b10000: begin d.esz = ESZ_Q; d.idx = {4'b0, imm[6:5]};  end
            default:  begin d.illegal = 1'b1;                          end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bcast_decode.sv
module bcast_decode
    import bcast_pkg::*;
(
    input  logic [1:0]        imm_hi,
    input  logic [CODE_W-1:0] imm_tsz,
    output dec_t              dec
);

    always_comb begin
        dec = decode_imm(imm_hi, imm_tsz);
    end

endmodule

// File: rtl/bcast_select.sv
module bcast_select
    import bcast_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int ES   = 8
) (
    input  logic [VLEN-1:0]  vec,
    input  logic [IDX_W-1:0] idx,
    output logic [ES-1:0]    elem,
    output logic             hit
);

    localparam int NE    = VLEN / ES;
    localparam int NSCAN = (NE < (1 << IDX_W)) ? NE : (1 << IDX_W);

    always_comb begin
        elem = '0;
        hit  = 1'b0;
        for (int k = 0; k < NSCAN; k++) begin
            if (int'(idx) == k) begin
                elem = vec[k*ES +: ES];
                hit  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bcast_fill.sv
module bcast_fill #(
    parameter int VLEN = 256,
    parameter int ES   = 8
) (
    input  logic [ES-1:0]   elem,
    output logic [VLEN-1:0] vec
);

    localparam int NE = VLEN / ES;

    for (genvar k = 0; k < NE; k++) begin : g_lane
        assign vec[k*ES +: ES] = elem;
    end

endmodule

// File: rtl/bcast_unit.sv
module bcast_unit
    import bcast_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VLEN-1:0]      req_vec,
    input  logic [1:0]           req_hi,
    input  logic [CODE_W-1:0]    req_tsz,
    output logic                 res_valid,
    output logic [VLEN-1:0]      res_vec,
    output logic                 res_illegal
);

    dec_t                   dec;
    logic [VLEN-1:0]        rep [NUM_SIZES];
    logic [NUM_SIZES-1:0]   hit;
    logic [VLEN-1:0]        next_vec;

    bcast_decode u_dec (
        .imm_hi  (req_hi),
        .imm_tsz (req_tsz),
        .dec     (dec)
    );

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int ES = esz_bits(s);
        logic [ES-1:0] elem;

        bcast_select #(.VLEN(VLEN), .ES(ES)) u_sel (
            .vec  (req_vec),
            .idx  (dec.idx),
            .elem (elem),
            .hit  (hit[s])
        );

        bcast_fill #(.VLEN(VLEN), .ES(ES)) u_fill (
            .elem (elem),
            .vec  (rep[s])
        );
    end

    always_comb begin
        next_vec = '0;
        if (!dec.illegal) begin
            case (dec.esz)
                ESZ_B:   next_vec = hit[0] ? rep[0] : '0;
                ESZ_H:   next_vec = hit[1] ? rep[1] : '0;
                ESZ_S:   next_vec = hit[2] ? rep[2] : '0;
                ESZ_D:   next_vec = hit[3] ? rep[3] : '0;
                ESZ_Q:   next_vec = hit[4] ? rep[4] : '0;
                default: next_vec = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            res_vec     <= '0;
        end else begin
            res_valid   <= req_valid;
            res_illegal <= req_valid & dec.illegal;
            if (req_valid) begin
                res_vec <= next_vec;
            end
        end
    end

endmodule

// File: rtl/bcast_unit_chk.sv
module bcast_unit_chk #(
    parameter int VLEN = 256
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [4:0]      req_tsz,
    input logic            res_valid,
    input logic [VLEN-1:0] res_vec,
    input logic            res_illegal
);

    logic [4:0] last_tsz;
    logic [4:0] per_ok;
    logic       per_sel;

    always_ff @(posedge clk) begin
        if (rst) last_tsz <= 5'b00001;
        else if (req_valid) last_tsz <= req_tsz;
    end

    for (genvar s = 0; s < 5; s++) begin : g_per
        localparam int ES = 8 << s;
        if (VLEN > ES) begin : g_cmp
            assign per_ok[s] = (res_vec[VLEN-1:ES] == res_vec[VLEN-1-ES:0]);
        end else begin : g_one
            assign per_ok[s] = 1'b1;
        end
    end

    always_comb begin
        if (last_tsz[0])      per_sel = per_ok[0];
        else if (last_tsz[1]) per_sel = per_ok[1];
        else if (last_tsz[2]) per_sel = per_ok[2];
        else if (last_tsz[3]) per_sel = per_ok[3];
        else                  per_sel = per_ok[4];
    end

    p_valid_lag_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && !res_illegal && $stable(res_vec)));

    p_rsv_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_tsz == 5'b00000) |=> res_illegal);

    p_illegal_zero_r4: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> (res_valid && res_vec == '0));

    p_periodic_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_illegal) |-> per_sel);

endmodule

bind bcast_unit bcast_unit_chk #(.VLEN(VLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_tsz     (req_tsz),
    .res_valid   (res_valid),
    .res_vec     (res_vec),
    .res_illegal (res_illegal)
);

// File: tb/bcast_unit_tb.sv
module bcast_unit_tb;

    localparam int VL      = 384;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [VL-1:0] req_vec = '0;
    logic [1:0]    req_hi = '0;
    logic [4:0]    req_tsz = '0;
    logic          res_valid;
    logic [VL-1:0] res_vec;
    logic          res_illegal;

    int total = 0;
    int bad   = 0;

    always #(CLK_PER/2) clk = ~clk;

    bcast_unit #(.VLEN(VL)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_vec     (req_vec),
        .req_hi      (req_hi),
        .req_tsz     (req_tsz),
        .res_valid   (res_valid),
        .res_vec     (res_vec),
        .res_illegal (res_illegal)
    );

    function automatic logic [VL-1:0] mkvec(input int seed);
        logic [VL-1:0] v;
        for (int i = 0; i < VL/8; i++) v[i*8 +: 8] = 8'(i*37 + seed*11 + 5);
        return v;
    endfunction

    // Independent reference: lowest set bit of the size code gives the width.
    task automatic model(input logic [VL-1:0] v, input logic [1:0] hi, input logic [4:0] tsz,
                         output logic [VL-1:0] ev, output logic eill);
        int p, es, idx;
        logic [127:0] el;
        logic [6:0] imm;
        imm = {hi, tsz};
        ev = '0; eill = 1'b0; p = -1;
        for (int b = 4; b >= 0; b--) if (tsz[b]) p = b;
        if (p < 0) begin eill = 1'b1; return; end
        es  = 8 << p;
        idx = int'(imm) >> (p + 1);
        if (idx >= VL / es) return;
        el = '0;
        for (int b = 0; b < es; b++) el[b] = v[idx*es + b];
        for (int b = 0; b < VL; b++) ev[b] = el[b % es];
    endtask

    task automatic chk_vec(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s vec act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s bit act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    // One request, result checked at the following negedge (R7 timing).
    task automatic apply(input string tag, input logic [VL-1:0] v, input logic [1:0] hi,
                         input logic [4:0] tsz);
        logic [VL-1:0] ev;
        logic eill;
        model(v, hi, tsz, ev, eill);
        @(negedge clk);
        req_valid = 1'b1; req_vec = v; req_hi = hi; req_tsz = tsz;
        @(negedge clk);
        req_valid = 1'b0;
        chk_bit({tag, " R7 valid"}, res_valid, 1'b1);
        chk_bit({tag, " illegal"}, res_illegal, eill);
        chk_vec(tag, res_vec, ev);
    endtask

    task automatic sweep_size(input int s, input string tag, input int seed);
        int nidx;
        logic [6:0] imm;
        nidx = 64 >> s;
        for (int i = 0; i < nidx; i++) begin
            imm = 7'((i << (s + 1)) | (1 << s));
            apply(tag, mkvec(seed + i), imm[6:5], imm[4:0]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_bit("R9 valid in reset", res_valid, 1'b0);
        chk_bit("R9 illegal in reset", res_illegal, 1'b0);
        chk_vec("R9 vec in reset", res_vec, '0);
    endtask

    task automatic t_bytes();       sweep_size(0, "R1 byte", 1); endtask
    task automatic t_half_word();   sweep_size(1, "R2 half", 2); sweep_size(2, "R2 word", 3); endtask
    task automatic t_dbl_quad();    sweep_size(3, "R3 dword", 4); sweep_size(4, "R3 quad", 5); endtask

    task automatic t_all_codes();
        for (int h = 0; h < 4; h++)
            for (int t = 0; t < 32; t++)
                apply("R6 code sweep", mkvec(h*32 + t), 2'(h), 5'(t));
    endtask

    task automatic t_reserved();
        for (int h = 0; h < 4; h++) begin
            apply("R4 reserved", mkvec(90 + h), 2'(h), 5'b00000);
            chk_bit("R4 flag", res_illegal, 1'b1);
            chk_vec("R4 zero", res_vec, '0);
        end
    endtask

    task automatic t_range();
        logic [VL-1:0] v;
        v = ~'0;
        // 384-bit vector: 3 quads, 6 dwords, 48 bytes.
        apply("R5 quad idx 2 in", v, 2'b10, 5'b10000);
        chk_vec("R5 quad idx 2 ones", res_vec, v);
        apply("R5 quad idx 3 out", v, 2'b11, 5'b10000);
        chk_vec("R5 quad idx 3 zero", res_vec, '0);
        chk_bit("R5 no flag", res_illegal, 1'b0);
        apply("R5 dword idx 6 out", v, 2'b11, 5'b01000);
        chk_vec("R5 dword idx 6 zero", res_vec, '0);
        apply("R5 byte idx 47 in", v, 2'b10, 5'b11111);
        chk_vec("R5 byte idx 47 ones", res_vec, v);
        apply("R5 byte idx 48 out", v, 2'b11, 5'b00001);
        chk_vec("R5 byte idx 48 zero", res_vec, '0);
    endtask

    task automatic t_idle();
        logic [VL-1:0] held;
        apply("R8 prime", mkvec(7), 2'b00, 5'b00011);
        held = res_vec;
        @(negedge clk);
        req_vec = mkvec(99); req_tsz = 5'b00000;
        repeat (3) begin
            @(negedge clk);
            chk_bit("R8 valid low", res_valid, 1'b0);
            chk_bit("R8 illegal low", res_illegal, 1'b0);
            chk_vec("R8 vec held", res_vec, held);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (2) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_bytes();
        t_half_word();
        t_dbl_quad();
        t_all_codes();
        t_reserved();
        t_range();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule